// File: doc/BRIEF.md
# Parallel-Port Bridge Register Engine

This engine sits on the host side of a PC-style parallel port and drives its 8-bit data lines and its control lines. It reads back the status, control and data lines. Through these lines it performs single register reads and writes on a parallel-to-IDE bridge device. It also plays the attach sequence that wakes the bridge and the detach sequence that hands the port back in the state it was found in.

The user side presents one request at a time: an operation code, a bank select, an 8-bit register address, write data and a transfer mode. Three legacy read modes are supported: nibble reads on the status lines, 5/3 split reads over the status and control-readback lines, and full 8-bit reads on the turned-around data lines. Writes always place the full byte on the data lines. Before it reaches the port, the register address is scrambled with an XOR key that depends on direction and mode. The read byte is assembled from the scattered bits that were captured.

Each operation is a fixed list of steps. A step drives the data lines, sets the control value, captures inputs, saves the port state, or ends the operation. Every step holds the port lines for a run-time programmable number of clock cycles before the next step fires.

Top module: `ppb_engine`

## Requirements
- R1: While reset is high and right after it: busy and done are 0, data lines 0x00, control lines 0x04, read data 0x00, data-output enable 1.
- R2: A request (op codes: 0 read, 1 write, 2 attach, 3 detach) is accepted only while busy is 0. Busy rises at the accepting clock edge and falls at the same edge that raises done. A request presented while busy is ignored and starts nothing after done.
- R3: Step 0 fires one cycle after acceptance and step k fires k·H cycles later, where H is the hold input or 1 if the hold input is 0. The lines stay unchanged between steps. Done fires H cycles after the last step.
- R4: With bank select 1 the effective address is the request address plus 0x80, modulo 256; with bank select 0 it is the address itself.
- R5: Mode 0 read, with r = address XOR 0x39: data r; control 1; control 3; data r; capture status; control 1; capture status; control 4. Result low nibble = first capture bits 7:4, high nibble = second capture bits 7:4.
- R6: Mode 1 read, with r = address XOR 0x31: data r; control 1; data r AND 0x37; control 3; control 5; data r OR 0xF0; capture status and control readback; control 4. Result bits 4:0 = status bits 7:3, bits 7:5 = control readback bits 3:1.
- R7: Mode 2 read, with r = address XOR 0x29: data r; control 1; control 0x21; control 0x23; capture data lines; control 4. The result is the captured byte. The data-output enable is low exactly while control bit 5 is set.
- R8: Write in every mode: data address XOR 0x19; control 1; data = write value; control 3; control 4.
- R9: Attach: save data and control readback; control 4; data 0xA0, 0x50, 0xC0, 0x30, 0xA0, 0x00; control 1; control 4; then a write of 0x08 to bank-1 register 0x06 (effective 0x86) as in R8.
- R10: Detach: data = saved data; control 1; control 4; data = saved data; control = saved control.
- R11: Done is a one-cycle pulse. Read data changes only at the done of a read; writes, attach and detach leave it unchanged.
- R12: Mode code 3 behaves exactly as mode 2, for reads and for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | Operation code (R2) |
| req_bank | input | 1 | Bank select, 1 adds 0x80 |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write value |
| req_mode | input | 2 | Transfer mode 0..3 |
| cfg_hold | input | HOLD_W | Cycles each step holds the lines (0 acts as 1) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last read result |
| pp_data_o | output | 8 | Data lines driven |
| pp_data_oe | output | 1 | Data-line output enable |
| pp_data_i | input | 8 | Data lines read back |
| pp_ctrl_o | output | 8 | Control value driven |
| pp_ctrl_i | input | 8 | Control lines read back |
| pp_status_i | input | 5 | Status lines 7:3 |

## Verification
The bench builds the engine with HOLD_W = 2, so the sweep reaches every hold setting, including the zero-means-one case, and the hold checks run cycle by cycle. Reads are swept over all 256 addresses in both banks and in all four mode codes. A model of the bridge answers with a per-transaction byte and fills the bits that must be ignored with junk, so each packing rule is exercised on every bit position. Writes, attach with two different saved port states, detach, and a request held high throughout a busy transaction are also checked.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_ATTACH = 2'd2,
    OP_DETACH = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    K_DATA, K_CTRL, K_SMP1, K_SMP2, K_SAVE, K_END
  } kind_e;

  typedef enum logic [2:0] {
    SRC_LIT, SRC_KEY, SRC_KEY_AND, SRC_KEY_OR, SRC_WDATA, SRC_SAVED
  } src_e;

  typedef struct packed {
    kind_e       kind;
    src_e        src;
    logic [7:0]  lit;
  } step_t;

  localparam int STEP_SLOTS = 16;
  localparam int IDX_W      = $clog2(STEP_SLOTS);

  localparam logic [7:0] KEY_RD_NIB  = 8'h39;
  localparam logic [7:0] KEY_RD_SPL  = 8'h31;
  localparam logic [7:0] KEY_RD_BYTE = 8'h29;
  localparam logic [7:0] KEY_WR      = 8'h19;
  localparam logic [7:0] BANK_OFS    = 8'h80;
  localparam logic [7:0] SPL_MASK    = 8'h37;
  localparam logic [7:0] SPL_SET     = 8'hF0;
  localparam logic [7:0] CTRL_IDLE   = 8'h04;
  localparam logic [7:0] WAKE_REG    = 8'h86;
  localparam logic [7:0] WAKE_VAL    = 8'h08;

  function automatic step_t st_data(src_e s, logic [7:0] l);
    return '{kind: K_DATA, src: s, lit: l};
  endfunction

  function automatic step_t st_ctrl(src_e s, logic [7:0] l);
    return '{kind: K_CTRL, src: s, lit: l};
  endfunction

  function automatic step_t st_evt(kind_e k);
    return '{kind: k, src: SRC_LIT, lit: 8'h00};
  endfunction
endpackage

// File: rtl/ppb_step_rom.sv
module ppb_step_rom
  import ppb_pkg::*;
(
  input  op_e              op,
  input  logic [1:0]       mode,
  input  logic [IDX_W-1:0] idx,
  output step_t            stp
);
  always_comb begin
    stp = st_evt(K_END);
    unique case (op)
      OP_READ: begin
        if (mode == 2'd0) begin
          case (int'(idx))
            0: stp = st_data(SRC_KEY, 8'h00);
            1: stp = st_ctrl(SRC_LIT, 8'h01);
            2: stp = st_ctrl(SRC_LIT, 8'h03);
            3: stp = st_data(SRC_KEY, 8'h00);
            4: stp = st_evt(K_SMP1);
            5: stp = st_ctrl(SRC_LIT, 8'h01);
            6: stp = st_evt(K_SMP2);
            7: stp = st_ctrl(SRC_LIT, CTRL_IDLE);
            default: stp = st_evt(K_END);
          endcase
        end else if (mode == 2'd1) begin
          case (int'(idx))
            0: stp = st_data(SRC_KEY, 8'h00);
            1: stp = st_ctrl(SRC_LIT, 8'h01);
            2: stp = st_data(SRC_KEY_AND, 8'h00);
            3: stp = st_ctrl(SRC_LIT, 8'h03);
            4: stp = st_ctrl(SRC_LIT, 8'h05);
            5: stp = st_data(SRC_KEY_OR, 8'h00);
            6: stp = st_evt(K_SMP1);
            7: stp = st_ctrl(SRC_LIT, CTRL_IDLE);
            default: stp = st_evt(K_END);
          endcase
        end else begin
          case (int'(idx))
            0: stp = st_data(SRC_KEY, 8'h00);
            1: stp = st_ctrl(SRC_LIT, 8'h01);
            2: stp = st_ctrl(SRC_LIT, 8'h21);
            3: stp = st_ctrl(SRC_LIT, 8'h23);
            4: stp = st_evt(K_SMP1);
            5: stp = st_ctrl(SRC_LIT, CTRL_IDLE);
            default: stp = st_evt(K_END);
          endcase
        end
      end
      OP_WRITE: begin
        case (int'(idx))
          0: stp = st_data(SRC_KEY, 8'h00);
          1: stp = st_ctrl(SRC_LIT, 8'h01);
          2: stp = st_data(SRC_WDATA, 8'h00);
          3: stp = st_ctrl(SRC_LIT, 8'h03);
          4: stp = st_ctrl(SRC_LIT, CTRL_IDLE);
          default: stp = st_evt(K_END);
        endcase
      end
      OP_ATTACH: begin
        case (int'(idx))
          0:  stp = st_evt(K_SAVE);
          1:  stp = st_ctrl(SRC_LIT, CTRL_IDLE);
          2:  stp = st_data(SRC_LIT, 8'hA0);
          3:  stp = st_data(SRC_LIT, 8'h50);
          4:  stp = st_data(SRC_LIT, 8'hC0);
          5:  stp = st_data(SRC_LIT, 8'h30);
          6:  stp = st_data(SRC_LIT, 8'hA0);
          7:  stp = st_data(SRC_LIT, 8'h00);
          8:  stp = st_ctrl(SRC_LIT, 8'h01);
          9:  stp = st_ctrl(SRC_LIT, CTRL_IDLE);
          10: stp = st_data(SRC_LIT, WAKE_REG ^ KEY_WR);
          11: stp = st_ctrl(SRC_LIT, 8'h01);
          12: stp = st_data(SRC_LIT, WAKE_VAL);
          13: stp = st_ctrl(SRC_LIT, 8'h03);
          14: stp = st_ctrl(SRC_LIT, CTRL_IDLE);
          default: stp = st_evt(K_END);
        endcase
      end
      OP_DETACH: begin
        case (int'(idx))
          0: stp = st_data(SRC_SAVED, 8'h00);
          1: stp = st_ctrl(SRC_LIT, 8'h01);
          2: stp = st_ctrl(SRC_LIT, CTRL_IDLE);
          3: stp = st_data(SRC_SAVED, 8'h00);
          4: stp = st_ctrl(SRC_SAVED, 8'h00);
          default: stp = st_evt(K_END);
        endcase
      end
    endcase
  end
endmodule

// File: rtl/ppb_hold_timer.sv
module ppb_hold_timer #(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              run,
  input  logic [HOLD_W-1:0] hold,
  output logic              zero
);
  logic [HOLD_W-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= '0;
    end else if (run) begin
      if (zero) cnt <= (hold == '0) ? '0 : hold - 1'b1;
      else      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ppb_byte_pack.sv
module ppb_byte_pack (
  input  logic [1:0] mode,
  input  logic [7:3] st1,
  input  logic [7:4] st2,
  input  logic [3:1] ct1,
  input  logic [7:0] dt1,
  output logic [7:0] byte_o
);
  always_comb begin
    unique case (mode)
      2'd0:    byte_o = {st2, st1[7:4]};
      2'd1:    byte_o = {ct1, st1};
      default: byte_o = dt1;
    endcase
  end
endmodule

// File: rtl/ppb_engine.sv
module ppb_engine
  import ppb_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_bank,
  input  logic [7:0]        req_addr,
  input  logic [7:0]        req_wdata,
  input  logic [1:0]        req_mode,
  input  logic [HOLD_W-1:0] cfg_hold,
  output logic              busy,
  output logic              done,
  output logic [7:0]        rdata,
  output logic [7:0]        pp_data_o,
  output logic              pp_data_oe,
  input  logic [7:0]        pp_data_i,
  output logic [7:0]        pp_ctrl_o,
  input  logic [7:0]        pp_ctrl_i,
  input  logic [7:3]        pp_status_i
);
  op_e              op_q;
  logic [1:0]       mode_q;
  logic [7:0]       addr_q;
  logic [7:0]       wdata_q;
  logic [IDX_W-1:0] idx;
  logic [7:0]       sav_d, sav_c;
  logic [7:3]       cap_st1;
  logic [7:4]       cap_st2;
  logic [3:1]       cap_ct1;
  logic [7:0]       cap_dt1;
  logic             accept, tmr_zero, fire;
  step_t            stp;
  logic [7:0]       key, keyed, dval, packed_byte;

  assign accept     = req_valid && !busy;
  assign fire       = busy && tmr_zero;
  assign pp_data_oe = ~pp_ctrl_o[5];

  ppb_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .run   (busy),
    .hold  (cfg_hold),
    .zero  (tmr_zero)
  );

  ppb_step_rom u_rom (
    .op   (op_q),
    .mode (mode_q),
    .idx  (idx),
    .stp  (stp)
  );

  ppb_byte_pack u_pack (
    .mode   (mode_q),
    .st1    (cap_st1),
    .st2    (cap_st2),
    .ct1    (cap_ct1),
    .dt1    (cap_dt1),
    .byte_o (packed_byte)
  );

  always_comb begin
    if (op_q == OP_READ) begin
      unique case (mode_q)
        2'd0:    key = KEY_RD_NIB;
        2'd1:    key = KEY_RD_SPL;
        default: key = KEY_RD_BYTE;
      endcase
    end else begin
      key = KEY_WR;
    end
    keyed = addr_q ^ key;
    unique case (stp.src)
      SRC_KEY:     dval = keyed;
      SRC_KEY_AND: dval = keyed & SPL_MASK;
      SRC_KEY_OR:  dval = keyed | SPL_SET;
      SRC_WDATA:   dval = wdata_q;
      SRC_SAVED:   dval = sav_d;
      default:     dval = stp.lit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      rdata     <= 8'h00;
      pp_data_o <= 8'h00;
      pp_ctrl_o <= CTRL_IDLE;
      op_q      <= OP_READ;
      mode_q    <= 2'd0;
      addr_q    <= 8'h00;
      wdata_q   <= 8'h00;
      idx       <= '0;
      sav_d     <= 8'h00;
      sav_c     <= CTRL_IDLE;
      cap_st1   <= '0;
      cap_st2   <= '0;
      cap_ct1   <= '0;
      cap_dt1   <= 8'h00;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        op_q    <= op_e'(req_op);
        mode_q  <= req_mode;
        addr_q  <= req_addr + (req_bank ? BANK_OFS : 8'h00);
        wdata_q <= req_wdata;
        idx     <= '0;
      end else if (fire) begin
        idx <= idx + 1'b1;
        unique case (stp.kind)
          K_DATA: pp_data_o <= dval;
          K_CTRL: pp_ctrl_o <= (stp.src == SRC_SAVED) ? sav_c : stp.lit;
          K_SMP1: begin
            cap_st1 <= pp_status_i;
            cap_ct1 <= pp_ctrl_i[3:1];
            cap_dt1 <= pp_data_i;
          end
          K_SMP2: cap_st2 <= pp_status_i[7:4];
          K_SAVE: begin
            sav_d <= pp_data_i;
            sav_c <= pp_ctrl_i;
          end
          default: begin
            busy <= 1'b0;
            done <= 1'b1;
            idx  <= '0;
            if (op_q == OP_READ) rdata <= packed_byte;
          end
        endcase
      end
    end
  end

  // Busy only ever drops together with the completion pulse.
  assert_busy_ends_with_done_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // An idle engine leaves the port lines alone, whatever is requested.
  assert_idle_lines_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |=> ($stable(pp_data_o) && $stable(pp_ctrl_o)));

  // Lines move only when the hold timer has run out.
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && !tmr_zero) |=> ($stable(pp_data_o) && $stable(pp_ctrl_o)));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_rdata_only_at_done_R11: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rdata));

  assert_accept_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);
endmodule

// File: tb/ppb_engine_bench.sv
module ppb_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic          req_bank = 1'b0;
  logic [7:0]    req_addr = 8'h00;
  logic [7:0]    req_wdata = 8'h00;
  logic [1:0]    req_mode = 2'd0;
  logic [HW-1:0] cfg_hold = '0;
  logic          busy, done, pp_data_oe;
  logic [7:0]    rdata, pp_data_o, pp_ctrl_o, pp_data_i, pp_ctrl_i;
  logic [7:3]    pp_status_i;

  logic [7:0] vbyte  = 8'h00;
  logic [7:0] idle_d = 8'h5A;
  logic [7:0] idle_c = 8'hCC;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bridge model: answers with vbyte, junk in the bits that must be dropped.
  assign pp_data_i   = (pp_ctrl_o == 8'h23) ? vbyte : idle_d;
  assign pp_status_i = (pp_ctrl_o == 8'h03) ? {vbyte[3:0], 1'b1} :
                       (pp_ctrl_o == 8'h01) ? {vbyte[7:4], 1'b0} :
                       (pp_ctrl_o == 8'h05) ? vbyte[4:0] : 5'b10101;
  assign pp_ctrl_i   = (pp_ctrl_o == 8'h05) ? {4'hC, vbyte[7:5], 1'b1} : idle_c;

  ppb_engine #(.HOLD_W(HW)) u_ppb_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_bank(req_bank), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mode(req_mode), .cfg_hold(cfg_hold), .busy(busy), .done(done),
    .rdata(rdata), .pp_data_o(pp_data_o), .pp_data_oe(pp_data_oe),
    .pp_data_i(pp_data_i), .pp_ctrl_o(pp_ctrl_o), .pp_ctrl_i(pp_ctrl_i),
    .pp_status_i(pp_status_i)
  );

  logic [7:0] ed [32];
  logic [7:0] ec [32];
  int         n;
  logic [7:0] cd = 8'h00, cc = 8'h04;
  logic [7:0] sd = 8'h00, sc = 8'h04;
  logic [7:0] exp_rd = 8'h00;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [7:0] c);
    ed[n] = d; ec[n] = c; n++; cd = d; cc = c;
  endtask

  task automatic build(input int op, input int mode, input logic [7:0] eff, input logic [7:0] w);
    logic [7:0] r;
    n = 0;
    case (op)
      0: begin
        if (mode == 0) begin
          r = eff ^ 8'h39;
          push(r, cc); push(r, 8'h01); push(r, 8'h03); push(r, 8'h03);
          push(r, 8'h03); push(r, 8'h01); push(r, 8'h01); push(r, 8'h04);
        end else if (mode == 1) begin
          r = eff ^ 8'h31;
          push(r, cc); push(r, 8'h01); push(r & 8'h37, 8'h01); push(r & 8'h37, 8'h03);
          push(r & 8'h37, 8'h05); push(r | 8'hF0, 8'h05); push(r | 8'hF0, 8'h05);
          push(r | 8'hF0, 8'h04);
        end else begin
          r = eff ^ 8'h29;
          push(r, cc); push(r, 8'h01); push(r, 8'h21); push(r, 8'h23);
          push(r, 8'h23); push(r, 8'h04);
        end
      end
      1: begin
        r = eff ^ 8'h19;
        push(r, cc); push(r, 8'h01); push(w, 8'h01); push(w, 8'h03); push(w, 8'h04);
      end
      2: begin
        sd = cd; sc = cc;  // model answers idle_d / idle_c with control at 4
        sd = idle_d; sc = idle_c;
        push(cd, cc); push(cd, 8'h04);
        push(8'hA0, 8'h04); push(8'h50, 8'h04); push(8'hC0, 8'h04);
        push(8'h30, 8'h04); push(8'hA0, 8'h04); push(8'h00, 8'h04);
        push(8'h00, 8'h01); push(8'h00, 8'h04);
        push(8'h86 ^ 8'h19, 8'h04); push(8'h86 ^ 8'h19, 8'h01);
        push(8'h08, 8'h01); push(8'h08, 8'h03); push(8'h08, 8'h04);
      end
      default: begin
        push(sd, cc); push(sd, 8'h01); push(sd, 8'h04); push(sd, 8'h04); push(sd, sc);
      end
    endcase
  endtask

  task automatic run(input int op, input bit bank, input logic [7:0] addr,
                     input logic [7:0] w, input int mode, input int hold,
                     input bit poke, input string tag0);
    logic [7:0]  eff;
    int          h, total;
    bit          ok;
    logic [16:0] bad_a, bad_e;
    string       tag;
    eff = addr + (bank ? 8'h80 : 8'h00);
    tag = bank ? {tag0, "+R4"} : tag0;
    build(op, mode, eff, w);
    h = (hold == 0) ? 1 : hold;
    total = 1 + n * h;
    @(negedge clk);
    req_op = 2'(op); req_bank = bank; req_addr = addr; req_wdata = w;
    req_mode = 2'(mode); cfg_hold = HW'(hold); req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R2 busy after accept", busy, 1);
    ok = 1'b1; bad_a = '0; bad_e = '0;
    for (int cyc = 1; cyc <= total; cyc++) begin
      @(posedge clk); @(negedge clk);
      if (poke && cyc == 2) begin
        req_valid = 1'b1; req_op = 2'd2; req_addr = 8'hEE; req_mode = 2'd1;
      end
      if (poke && cyc == n * h) req_valid = 1'b0;
      if (cyc < total) begin
        int s;
        logic [16:0] a, e;
        s = (cyc - 1) / h;
        a = {pp_data_oe, pp_data_o, pp_ctrl_o};
        e = {~ec[s][5], ed[s], ec[s]};
        if (ok && (a !== e || busy !== 1'b1 || done !== 1'b0)) begin
          ok = 1'b0; bad_a = a; bad_e = e;
        end
      end
    end
    chk(ok, {tag, " line trace R3 R7"}, bad_a, bad_e);
    chk(done === 1'b1 && busy === 1'b0, "R11 done at end", {busy, done}, 2'b01);
    if (op == 0) exp_rd = vbyte;
    chk(rdata === exp_rd, (op == 0) ? {tag, " read byte"} : "R11 rdata kept", rdata, exp_rd);
    @(posedge clk); @(negedge clk);
    chk(done === 1'b0, "R11 done one cycle", done, 0);
    if (poke) begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(busy === 1'b0 && pp_data_o === cd && pp_ctrl_o === cc,
          "R2 request while busy ignored", {busy, pp_data_o, pp_ctrl_o}, {1'b0, cd, cc});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL R3 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({busy, done, pp_data_o, pp_ctrl_o, rdata, pp_data_oe} === {2'b00, 8'h00, 8'h04, 8'h00, 1'b1},
        "R1 state in reset", {busy, done, pp_data_o, pp_ctrl_o, rdata, pp_data_oe},
        {2'b00, 8'h00, 8'h04, 8'h00, 1'b1});
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    chk({busy, done, pp_data_o, pp_ctrl_o, rdata} === {2'b00, 8'h00, 8'h04, 8'h00},
        "R1 state after reset", {busy, done, pp_data_o, pp_ctrl_o, rdata},
        {2'b00, 8'h00, 8'h04, 8'h00});

    run(2, 1'b0, 8'h00, 8'h00, 0, 1, 1'b0, "R9 attach");

    for (int b = 0; b < 2; b++)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < 256; a++) begin
          vbyte = 8'(a * 37 + m * 11 + b);
          run(0, b[0], 8'(a), 8'h00, m, (a + m) % 4, 1'b0,
              (m == 0) ? "R5 mode0" : (m == 1) ? "R6 mode1" : (m == 2) ? "R7 mode2" : "R12 mode3");
        end

    for (int a = 0; a < 256; a++)
      run(1, a[1], 8'(a), 8'(a ^ 8'h3C), a % 4, a % 4, 1'b0,
          (a % 4 == 3) ? "R8 R12 write" : "R8 write");

    vbyte = 8'hC3;
    run(0, 1'b0, 8'h07, 8'h00, 0, 2, 1'b1, "R5 mode0 poke");
    run(3, 1'b0, 8'h00, 8'h00, 0, 3, 1'b0, "R10 detach");

    idle_d = 8'h96; idle_c = 8'h0B;
    run(2, 1'b0, 8'h00, 8'h00, 1, 2, 1'b0, "R9 attach2");
    run(3, 1'b0, 8'h00, 8'h00, 2, 0, 1'b1, "R10 detach2");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule